// File: doc/BRIEF.md
# DRAM Data Return Pipeline

This block is the data-bus stage of a DRAM channel controller. It sits after the column command scheduler and before the reply path. Every read or write column command that the scheduler issues is pushed into a delay queue, with the request tag, the total request size in bytes, and whether the request is a cache writeback. An entry may not leave the queue until a minimum residency time has passed. That time is the read latency while the channel is in read mode and the write latency while it is in write mode. The channel changes mode whenever a pushed command's direction differs from the current mode.

Eligible entries leave strictly in order, at most one per cycle. Each departure credits one data atom to its request's running byte tally. A request may be spread over several column commands. When its tally reaches or passes the request size, the request is complete. A completed writeback produces a one-cycle done strobe carrying its tag. Any other completed request is queued as a reply for the consumer. The stage stops draining entirely while the reply queue is full. It raises a full flag so the scheduler stops issuing column commands while the delay queue is full.

Top module: `dram_data_return`

## Requirements
- R1: After a synchronous reset the channel is in read mode, both queues are empty, `cmd_full`, `rsp_valid` and `wb_done` are 0, and every byte tally is 0.
- R2: A single-atom command pushed in read mode becomes visible at the output no earlier and no later than RD_LAT cycles after its push edge, provided nothing is ahead of it and the reply queue has room.
- R3: A push whose direction (`cmd_write`=1 write, 0 read) differs from the current mode switches the mode. That push and later ones wait WR_LAT (write) or RD_LAT (read). An entry already queued keeps the residency it was given when pushed.
- R4: The delay queue holds RD_LAT+1 entries. `cmd_full` is 1 exactly while it holds that many, and a push while `cmd_full` is 1 is discarded with no effect on any output.
- R5: Entries leave the delay queue in push order, at most one per cycle. An eligible entry behind a waiting head waits for the head.
- R6: No entry leaves the delay queue in a cycle in which the reply queue holds REPLY_DEPTH entries.
- R7: Each departure adds ATOM_BYTES to the tally for its tag. The request completes on the departure that brings the tally to at least `cmd_bytes`, and the tally then returns to 0. Earlier departures produce no output.
- R8: A completed request pushed with `cmd_wb`=1 raises `wb_done` for exactly one cycle, with its tag on `wb_id`, in the cycle after its final departure edge. It places nothing in the reply queue.
- R9: Any other completed request enters the reply queue, which holds REPLY_DEPTH tags. The tags are presented first in first out on `rsp_id` while `rsp_valid` is 1, and one is removed on each cycle with `rsp_ready` and `rsp_valid` both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Column command push |
| cmd_write | input | 1 | Push direction: 1 write, 0 read |
| cmd_wb | input | 1 | Request is a cache writeback |
| cmd_id | input | ID_W | Request tag |
| cmd_bytes | input | SIZE_W | Total request size in bytes |
| cmd_full | output | 1 | Delay queue full; scheduler must hold off |
| rsp_valid | output | 1 | Reply queue not empty |
| rsp_id | output | ID_W | Tag at the head of the reply queue |
| rsp_ready | input | 1 | Consumer takes the head reply |
| wb_done | output | 1 | One-cycle writeback completion strobe |
| wb_id | output | ID_W | Tag of the completed writeback |

## Verification
The bench measures the exact latency of single-atom reads and writes, including the cycle where a read pushed just before a write must keep the longer read residency. A design that re-timed queued entries on a mode switch would release that read two cycles early, and one that reordered by eligibility would let the write overtake it. A three-command request with a size that is not a multiple of the atom checks that only the last departure completes it: an off-by-one in the tally compare gives a missing reply or an early one. A stalled consumer fills the reply queue and then the delay queue. A design that kept draining would lose tags, one that ignored the full flag would accept a discarded tag, and one that sent writebacks to the reply queue would show extra replies.

// File: rtl/dram_ret_pkg.sv
package dram_ret_pkg;

  // Transfer direction the channel is currently turned for.
  typedef enum logic {
    DIR_READ  = 1'b0,
    DIR_WRITE = 1'b1
  } dir_e;

  // Width of a counter able to hold 0 .. depth.
  function automatic int occ_width(input int depth);
    return $clog2(depth + 1);
  endfunction

endpackage

// File: rtl/rp_fifo.sv
module rp_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic [CNT_W-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic             wr_ok;
  logic             rd_ok;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign wr_ok = wr_en && (count != CNT_W'(DEPTH));
  assign rd_ok = rd_en && (count != '0);

  // Storage has no reset so it can map onto RAM.
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_ok) wr_ptr <= bump(wr_ptr);
      if (rd_ok) rd_ptr <= bump(rd_ptr);
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign rd_data = mem[rd_ptr];

endmodule

// File: rtl/rp_byte_tally.sv
module rp_byte_tally #(
  parameter int ID_W       = 5,
  parameter int SIZE_W     = 8,
  parameter int ATOM_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_en,
  input  logic [ID_W-1:0]   upd_id,
  input  logic [SIZE_W-1:0] req_bytes,
  output logic              done
);
  localparam int NUM_IDS = 1 << ID_W;
  localparam int ACC_W   = SIZE_W + 1;

  logic [ACC_W-1:0] acc [NUM_IDS];
  logic [ACC_W-1:0] sum;

  // Running total including the atom being delivered now.
  assign sum  = acc[upd_id] + ACC_W'(ATOM_BYTES);
  assign done = (sum >= {1'b0, req_bytes});

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_IDS; i++) acc[i] <= '0;
    end else if (upd_en) begin
      acc[upd_id] <= done ? '0 : sum;
    end
  end

endmodule

// File: rtl/rp_stamp.sv
module rp_stamp #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TS_W-1:0] now
);
  always_ff @(posedge clk) begin
    if (rst) now <= '0;
    else     now <= now + TS_W'(1);
  end
endmodule

// File: rtl/dram_data_return.sv
module dram_data_return
  import dram_ret_pkg::*;
#(
  parameter int ID_W        = 5,
  parameter int SIZE_W      = 8,
  parameter int ATOM_BYTES  = 32,
  parameter int RD_LAT      = 5,
  parameter int WR_LAT      = 3,
  parameter int REPLY_DEPTH = 4,
  parameter int TS_W        = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic              cmd_wb,
  input  logic [ID_W-1:0]   cmd_id,
  input  logic [SIZE_W-1:0] cmd_bytes,
  output logic              cmd_full,
  output logic              rsp_valid,
  output logic [ID_W-1:0]   rsp_id,
  input  logic              rsp_ready,
  output logic              wb_done,
  output logic [ID_W-1:0]   wb_id
);
  localparam int DQ_DEPTH = RD_LAT + 1;
  localparam int DQ_CW    = occ_width(DQ_DEPTH);
  localparam int RQ_CW    = occ_width(REPLY_DEPTH);

  typedef struct packed {
    logic              wb;
    logic [ID_W-1:0]   id;
    logic [SIZE_W-1:0] bytes;
    logic [TS_W-1:0]   due;
  } ent_t;
  localparam int ENT_W = $bits(ent_t);

  // Mode register and latency selection
  dir_e            mode_q;
  dir_e            mode_nx;
  logic            mode_wr;
  logic [TS_W-1:0] push_lat;
  logic [TS_W-1:0] now;
  logic            push_ok;

  assign push_ok  = cmd_valid && !cmd_full;
  assign mode_nx  = push_ok ? (cmd_write ? DIR_WRITE : DIR_READ) : mode_q;
  assign push_lat = (mode_nx == DIR_WRITE) ? TS_W'(WR_LAT) : TS_W'(RD_LAT);
  assign mode_wr  = (mode_q == DIR_WRITE);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= DIR_READ;
    else     mode_q <= mode_nx;
  end

  rp_stamp #(.TS_W(TS_W)) stamp_i (
    .clk (clk),
    .rst (rst),
    .now (now)
  );

  // Delay queue
  ent_t             push_ent;
  ent_t             head;
  logic [ENT_W-1:0] head_raw;
  logic [DQ_CW-1:0] dq_count;
  logic [TS_W-1:0]  slack;
  logic             head_ready;
  logic             drain;

  assign push_ent.wb    = cmd_wb;
  assign push_ent.id    = cmd_id;
  assign push_ent.bytes = cmd_bytes;
  assign push_ent.due   = now + push_lat;

  rp_fifo #(.WIDTH(ENT_W), .DEPTH(DQ_DEPTH)) delay_q_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (push_ok),
    .wr_data (push_ent),
    .rd_en   (drain),
    .rd_data (head_raw),
    .count   (dq_count)
  );

  assign head       = ent_t'(head_raw);
  assign cmd_full   = (dq_count == DQ_CW'(DQ_DEPTH));
  // Wrap-safe "now has reached due" test on the timestamp.
  assign slack      = now - head.due;
  assign head_ready = (dq_count != '0) && !slack[TS_W-1];

  // Reply queue
  logic [RQ_CW-1:0] rq_count;
  logic             rq_full;
  logic             req_done;
  logic             rq_push;
  logic [ID_W-1:0]  rq_head;

  assign rq_full = (rq_count == RQ_CW'(REPLY_DEPTH));
  assign drain   = head_ready && !rq_full;
  assign rq_push = drain && req_done && !head.wb;

  rp_byte_tally #(
    .ID_W       (ID_W),
    .SIZE_W     (SIZE_W),
    .ATOM_BYTES (ATOM_BYTES)
  ) tally_i (
    .clk       (clk),
    .rst       (rst),
    .upd_en    (drain),
    .upd_id    (head.id),
    .req_bytes (head.bytes),
    .done      (req_done)
  );

  rp_fifo #(.WIDTH(ID_W), .DEPTH(REPLY_DEPTH)) reply_q_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (rq_push),
    .wr_data (head.id),
    .rd_en   (rsp_ready),
    .rd_data (rq_head),
    .count   (rq_count)
  );

  assign rsp_valid = (rq_count != '0);
  assign rsp_id    = rq_head;

  // Writeback completion strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      wb_done <= 1'b0;
      wb_id   <= '0;
    end else begin
      wb_done <= drain && req_done && head.wb;
      if (drain && req_done && head.wb) wb_id <= head.id;
    end
  end

endmodule

// File: rtl/dram_data_return_chk.sv
module dram_data_return_chk #(
  parameter int DQ_DEPTH    = 6,
  parameter int REPLY_DEPTH = 4,
  parameter int DQ_CW       = 3,
  parameter int RQ_CW       = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic             cmd_write,
  input logic             cmd_full,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             wb_done,
  input logic             mode_wr,
  input logic [DQ_CW-1:0] dq_count,
  input logic [RQ_CW-1:0] rq_count
);

  // R1: outputs idle right after reset
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rsp_valid && !wb_done && !cmd_full));

  // R3: mode follows the direction of an accepted push
  assert_mode_follows_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_full) |=> (mode_wr == $past(cmd_write)));

  // R4: a push offered while full does not grow the queue
  assert_full_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_full) |=> (dq_count <= $past(dq_count)));

  // R4: occupancy bound
  assert_dq_bound_R4: assert property (@(posedge clk) disable iff (rst)
    int'(dq_count) <= DQ_DEPTH);

  // R5: at most one reply enters per cycle
  assert_one_per_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (int'(rq_count) <= int'($past(rq_count)) + 1));

  // R6: full reply queue with no consumer stays exactly full
  assert_no_drain_R6: assert property (@(posedge clk) disable iff (rst)
    ((int'(rq_count) == REPLY_DEPTH) && !rsp_ready) |=> (int'(rq_count) == REPLY_DEPTH));

  // R8: a writeback completion adds nothing to the reply queue
  assert_wb_no_reply_R8: assert property (@(posedge clk) disable iff (rst)
    wb_done |-> (int'(rq_count) + ($past(rsp_valid && rsp_ready) ? 1 : 0) == int'($past(rq_count))));

endmodule

bind dram_data_return dram_data_return_chk #(
  .DQ_DEPTH    (DQ_DEPTH),
  .REPLY_DEPTH (REPLY_DEPTH),
  .DQ_CW       (DQ_CW),
  .RQ_CW       (RQ_CW)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_write (cmd_write),
  .cmd_full  (cmd_full),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .wb_done   (wb_done),
  .mode_wr   (mode_wr),
  .dq_count  (dq_count),
  .rq_count  (rq_count)
);

// File: tb/dram_data_return_tb_top.sv
module dram_data_return_tb_top;
  localparam int ID_W = 5, SIZE_W = 8, ATOM = 32, RD = 5, WR = 3, RDEP = 4;
  localparam int DQ = RD + 1;
  localparam int NIDS = 1 << ID_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_write = 1'b0, cmd_wb = 1'b0;
  logic [ID_W-1:0] cmd_id = '0;
  logic [SIZE_W-1:0] cmd_bytes = '0;
  logic cmd_full, rsp_valid, wb_done;
  logic [ID_W-1:0] rsp_id, wb_id;
  logic rsp_ready = 1'b1;

  always #10 clk = ~clk;  // 50 MHz

  dram_data_return #(
    .ID_W(ID_W), .SIZE_W(SIZE_W), .ATOM_BYTES(ATOM),
    .RD_LAT(RD), .WR_LAT(WR), .REPLY_DEPTH(RDEP), .TS_W(16)
  ) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_wb(cmd_wb), .cmd_id(cmd_id), .cmd_bytes(cmd_bytes),
    .cmd_full(cmd_full), .rsp_valid(rsp_valid), .rsp_id(rsp_id),
    .rsp_ready(rsp_ready), .wb_done(wb_done), .wb_id(wb_id)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model: behavioural queues
  typedef struct { int id; bit wb; int bytes; int due; } ent_t;
  ent_t mq[$];
  int   rq[$];
  int   deliv [NIDS];
  bit   m_wb = 0;
  int   m_wbid = 0;
  int   tb_cyc = 0;
  int   rcount [NIDS];
  int   first  [NIDS];
  int   wbfirst[NIDS];

  initial begin
    for (int i = 0; i < NIDS; i++) begin
      rcount[i] = 0; first[i] = -1; wbfirst[i] = -1; deliv[i] = 0;
    end
  end

  always @(posedge clk) begin
    bit do_rpop, do_drain, full_pre;
    ent_t e;
    if (rst) begin
      mq.delete(); rq.delete(); m_wb = 0;
      for (int i = 0; i < NIDS; i++) deliv[i] = 0;
    end else begin
      if (rsp_valid && rsp_ready) rcount[rsp_id]++;
      do_rpop  = rsp_ready && (rq.size() > 0);
      do_drain = (mq.size() > 0) && (tb_cyc >= mq[0].due) && (rq.size() < RDEP);
      full_pre = (mq.size() >= DQ);
      m_wb = 0;
      if (do_rpop) void'(rq.pop_front());
      if (do_drain) begin
        e = mq.pop_front();
        deliv[e.id] += ATOM;
        if (deliv[e.id] >= e.bytes) begin
          deliv[e.id] = 0;
          if (e.wb) begin m_wb = 1; m_wbid = e.id; end
          else rq.push_back(e.id);
        end
      end
      if (cmd_valid && !full_pre) begin
        e.id = int'(cmd_id); e.wb = cmd_wb; e.bytes = int'(cmd_bytes);
        e.due = tb_cyc + (cmd_write ? WR : RD);
        mq.push_back(e);
      end
    end
    tb_cyc++;
  end

  // Per-cycle comparison and event capture
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(rsp_valid == (rq.size() > 0), "R9 rsp_valid vs model", int'(rsp_valid), int'(rq.size() > 0));
      if (rq.size() > 0) check(int'(rsp_id) == rq[0], "R9 rsp_id vs model", int'(rsp_id), rq[0]);
      check(cmd_full == (mq.size() >= DQ), "R4 cmd_full vs model", int'(cmd_full), int'(mq.size() >= DQ));
      check(wb_done == m_wb, "R8 wb_done vs model", int'(wb_done), int'(m_wb));
      if (m_wb) check(int'(wb_id) == m_wbid, "R8 wb_id vs model", int'(wb_id), m_wbid);
      if (rsp_valid && first[rsp_id] < 0) first[rsp_id] = tb_cyc;
      if (wb_done && wbfirst[wb_id] < 0) wbfirst[wb_id] = tb_cyc;
    end
  end

  task automatic push(input int id, input bit wr, input bit wb, input int bytes, output int pc);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_wb = wb;
    cmd_id = ID_W'(id); cmd_bytes = SIZE_W'(bytes);
    pc = tb_cyc;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      cmd_valid = 1'b0;
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    int p1, p2, p3, p4, p5, p6a, p6b, p6c, p7, rel, dummy;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!cmd_full && !rsp_valid && !wb_done, "R1 reset outputs idle", int'({cmd_full, rsp_valid, wb_done}), 0);

    // R2: read latency
    push(1, 0, 0, ATOM, p1); idle(10);
    check(first[1] - p1 - 1 == RD, "R2 read latency", first[1] - p1 - 1, RD);

    // R3: switch to write, then back to read
    push(2, 1, 0, ATOM, p2); idle(10);
    check(first[2] - p2 - 1 == WR, "R3 write latency after switch", first[2] - p2 - 1, WR);
    push(3, 0, 0, ATOM, p3); idle(10);
    check(first[3] - p3 - 1 == RD, "R3 read latency after switch back", first[3] - p3 - 1, RD);

    // R3/R5: read in flight keeps RD, following write waits behind it
    push(4, 0, 0, ATOM, p4); push(5, 1, 0, ATOM, p5); idle(12);
    check(first[4] - p4 - 1 == RD, "R3 in-flight read keeps latency", first[4] - p4 - 1, RD);
    check(first[5] == first[4] + 1, "R5 write waits behind head", first[5], first[4] + 1);

    // R7: three atoms, size not a multiple of the atom
    push(6, 0, 0, 3 * ATOM - 1, p6a); push(6, 0, 0, 3 * ATOM - 1, p6b);
    push(6, 0, 0, 3 * ATOM - 1, p6c); idle(12);
    check(first[6] - p6c - 1 == RD, "R7 completes on last atom", first[6] - p6c - 1, RD);
    check(rcount[6] == 1, "R7 single reply for multi-atom request", rcount[6], 1);

    // R8: writeback
    push(7, 1, 1, ATOM, p7); idle(10);
    check(wbfirst[7] - p7 - 1 == WR, "R8 writeback strobe timing", wbfirst[7] - p7 - 1, WR);
    check(rcount[7] == 0 && first[7] < 0, "R8 writeback gives no reply", rcount[7], 0);

    // R6/R9/R4: stalled consumer
    @(negedge clk); rsp_ready = 1'b0;
    for (int k = 8; k <= 13; k++) push(k, 0, 0, ATOM, dummy);
    idle(20);
    check(rsp_valid && int'(rsp_id) == 8, "R9 head of full reply queue", int'(rsp_id), 8);
    check(!cmd_full, "R6 two entries held in delay queue", int'(cmd_full), 0);
    for (int k = 14; k <= 17; k++) push(k, 0, 0, ATOM, dummy);
    idle(1);
    check(cmd_full, "R4 full at RD_LAT+1 entries", int'(cmd_full), 1);
    push(0, 0, 0, ATOM, dummy); idle(5);
    check(int'(rsp_id) == 8, "R6 reply head unchanged while stalled", int'(rsp_id), 8);
    @(negedge clk); rsp_ready = 1'b1; rel = tb_cyc;
    idle(60);
    check(first[12] > rel, "R6 no drain while reply queue full", first[12], rel + 1);
    for (int k = 8; k <= 16; k++)
      check(first[k] < first[k + 1], "R9 reply order", first[k + 1], first[k] + 1);
    for (int k = 8; k <= 17; k++)
      check(rcount[k] == 1, "R9 one reply per request", rcount[k], 1);
    check(rcount[0] == 0 && first[0] < 0, "R4 push while full discarded", rcount[0], 0);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
      $finish;
    end
  end

endmodule